// File: doc/BRIEF.md
# CAN Controller Register Access Guard

This block is the register front-end of a CAN controller. It holds the master control word and stores the bit-timing, acceptance-filter configuration, filter-bank values and transmit-mailbox words. The block decides, write by write, whether the current controller mode allows that write. A write that the mode forbids is dropped without effect, and a one-cycle reject pulse reports it. A software reset bit in the control word returns the control word to its power-up value and requests sleep. Together with the debug-halt input, the debug-freeze bit produces a freeze signal for the protocol engine.

The bus is a plain 32-bit word interface with byte strobes. Only full-word accesses are honoured. Operating-mode status comes in on dedicated inputs: initialization active, filter-init, one empty flag for each mailbox, and debug halt. Read data is registered and appears one clock after the read strobe.

Word map (byte offsets): control 0x000, bit timing 0x004, filter mode 0x008, filter scale 0x00C, filter FIFO assignment 0x010, filter activation 0x014, filter values at 0x100 + 8·bank + 4·word (two words per bank), and mailbox words at 0x200 + 16·mailbox + 4·word (four words per mailbox).

Top module: `can_reg_guard`

## Requirements
- R1: A write with any byte strobe low changes no register and raises no reset pulse. It also raises wr_reject. A read with any strobe low returns 0.
- R2: The bit-timing word (0x004) takes writes only while init_active is 1. At other times it keeps its value.
- R3: A word of mailbox m takes writes only while mb_empty[m] is 1.
- R4: The filter mode, scale and FIFO-assignment words (0x008 to 0x010) take writes only while filt_init is 1.
- R5: The activation word (0x014) is always writable, and bit b set marks bank b active. A filter value word of bank b takes writes when filt_init is 1 or bank b is inactive.
- R6: After reset the control word reads 0x0001_0002. Bits 7:0 are plain read/write bits. sleep_req follows bit 1 and init_req follows bit 0.
- R7: A full-word write to 0x000 with bit 15 set returns the control word to 0x0001_0002 and ignores the other written bits. It pulses soft_rst_pulse for exactly one cycle, and bit 15 always reads 0.
- R8: freeze is 1 one cycle after control bit 16 and dbg_halt are both 1, and 0 one cycle after either of them is 0.
- R9: Control bits 31:17 and 14:8 always read 0 and cannot be written.
- R10: wr_reject is a one-cycle pulse in the cycle after a dropped write. Accepted writes and writes to unmapped offsets do not raise it.
- R11: Reads of unmapped or unaligned offsets return 0. Read data appears on bus_rdata one cycle after bus_re and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_be | input | 4 | Byte strobes, all four needed |
| init_active | input | 1 | Controller in initialization mode |
| filt_init | input | 1 | Filter initialization flag |
| mb_empty | input | NUM_MB | Per-mailbox empty flag |
| dbg_halt | input | 1 | Debug halt from the system |
| bus_rdata | output | 32 | Registered read data |
| soft_rst_pulse | output | 1 | One-cycle software reset pulse |
| freeze | output | 1 | Stop reception and transmission |
| sleep_req | output | 1 | Sleep mode request |
| init_req | output | 1 | Initialization mode request |
| wr_reject | output | 1 | Dropped-write pulse |

## Verification
Some properties are checked on every cycle. The bit-timing word stays stable after any write outside initialization mode. Partial-strobe writes leave the control word untouched. The reset pulse lasts exactly one cycle and always coincides with the reset value. freeze only follows a halted cycle, reserved control bits and unmapped reads return zero, and every reject pulse follows a write. The bench scenarios are needed for the rest. They show the mailbox and filter gating with their per-bank and per-mailbox selection, the readback of accepted values, the activation word changing which filter writes pass, and the full sequence of control-bit storage and software reset.

// File: rtl/can_reg_pkg.sv
package can_reg_pkg;
  typedef enum logic [2:0] {
    RG_NONE, RG_MCR, RG_BTR, RG_FCFG, RG_FACT, RG_FVAL, RG_MBOX
  } region_e;

  localparam logic [31:0] MCR_RESET = 32'h0001_0002;
  localparam logic [31:0] MCR_WMASK = 32'h0001_00FF;
  localparam int MCR_RST_BIT   = 15;
  localparam int MCR_DBF_BIT   = 16;
  localparam int MCR_SLEEP_BIT = 1;
  localparam int MCR_INRQ_BIT  = 0;

  // word offsets
  localparam int W_MCR       = 0;
  localparam int W_BTR       = 1;
  localparam int W_FMODE     = 2;
  localparam int W_FFIFO     = 4;
  localparam int W_FACT      = 5;
  localparam int W_FVAL_BASE = 64;
  localparam int W_MBOX_BASE = 128;
  localparam int FCFG_N      = 3;
endpackage

// File: rtl/can_reg_decode.sv
module can_reg_decode
  import can_reg_pkg::*;
#(
  parameter int WIDX_W      = 8,
  parameter int NUM_BANKS   = 14,
  parameter int FBANK_WORDS = 2,
  parameter int NUM_MB      = 3,
  parameter int MB_WORDS    = 4,
  parameter int IDX_W       = 5
) (
  input  logic [WIDX_W-1:0]    widx_i,
  input  logic                 aligned_i,
  input  logic                 init_active_i,
  input  logic                 filt_init_i,
  input  logic [NUM_MB-1:0]    mb_empty_i,
  input  logic [NUM_BANKS-1:0] fact_i,
  output region_e              region_o,
  output logic [IDX_W-1:0]     sub_o,
  output logic                 allowed_o
);
  localparam int FV_WORDS = NUM_BANKS * FBANK_WORDS;
  localparam int MB_TOTAL = NUM_MB * MB_WORDS;

  always_comb begin
    int w;
    int owner;
    w         = int'(widx_i);
    owner     = 0;
    region_o  = RG_NONE;
    sub_o     = '0;
    allowed_o = 1'b0;
    if (!aligned_i) begin
      region_o = RG_NONE;
    end else if (w == W_MCR) begin
      region_o  = RG_MCR;
      allowed_o = 1'b1;
    end else if (w == W_BTR) begin
      region_o  = RG_BTR;
      allowed_o = init_active_i;
    end else if (w >= W_FMODE && w <= W_FFIFO) begin
      region_o  = RG_FCFG;
      sub_o     = IDX_W'(w - W_FMODE);
      allowed_o = filt_init_i;
    end else if (w == W_FACT) begin
      region_o  = RG_FACT;
      allowed_o = 1'b1;
    end else if (w >= W_FVAL_BASE && w < W_FVAL_BASE + FV_WORDS) begin
      region_o = RG_FVAL;
      sub_o    = IDX_W'(w - W_FVAL_BASE);
      owner    = (w - W_FVAL_BASE) / FBANK_WORDS;
      for (int b = 0; b < NUM_BANKS; b++)
        if (b == owner) allowed_o = filt_init_i | ~fact_i[b];
    end else if (w >= W_MBOX_BASE && w < W_MBOX_BASE + MB_TOTAL) begin
      region_o = RG_MBOX;
      sub_o    = IDX_W'(w - W_MBOX_BASE);
      owner    = (w - W_MBOX_BASE) / MB_WORDS;
      for (int m = 0; m < NUM_MB; m++)
        if (m == owner) allowed_o = mb_empty_i[m];
    end
  end
endmodule

// File: rtl/can_mcr.sv
module can_mcr
  import can_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] mcr_o,
  output logic        soft_rst_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mcr_o      <= MCR_RESET;
      soft_rst_o <= 1'b0;
    end else begin
      soft_rst_o <= 1'b0;
      if (wr_i) begin
        if (wdata_i[MCR_RST_BIT]) begin
          mcr_o      <= MCR_RESET;
          soft_rst_o <= 1'b1;
        end else begin
          mcr_o <= wdata_i & MCR_WMASK;
        end
      end
    end
  end

  AST_RST_VALUE: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |-> (mcr_o == MCR_RESET)); // R7
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |=> !soft_rst_o); // R7
endmodule

// File: rtl/can_cfg_store.sv
module can_cfg_store
  import can_reg_pkg::*;
#(
  parameter int NUM_BANKS   = 14,
  parameter int FBANK_WORDS = 2,
  parameter int NUM_MB      = 3,
  parameter int MB_WORDS    = 4,
  parameter int IDX_W       = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_i,
  input  region_e              region_i,
  input  logic [IDX_W-1:0]     sub_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          btr_o,
  output logic [NUM_BANKS-1:0] fact_o,
  output logic [31:0]          rd_o
);
  localparam int FV_WORDS = NUM_BANKS * FBANK_WORDS;
  localparam int MB_TOTAL = NUM_MB * MB_WORDS;
  localparam int FV_IW    = (FV_WORDS > 1) ? $clog2(FV_WORDS) : 1;
  localparam int MB_IW    = (MB_TOTAL > 1) ? $clog2(MB_TOTAL) : 1;

  logic [31:0] fcfg_q [FCFG_N];
  logic [31:0] fv_mem [FV_WORDS];
  logic [31:0] mb_mem [MB_TOTAL];

  always_ff @(posedge clk) begin
    if (rst) begin
      btr_o  <= '0;
      fact_o <= '0;
      for (int i = 0; i < FCFG_N; i++) fcfg_q[i] <= '0;
    end else if (wr_i) begin
      case (region_i)
        RG_BTR:  btr_o <= wdata_i;
        RG_FCFG: fcfg_q[sub_i[1:0]] <= wdata_i;
        RG_FACT: fact_o <= wdata_i[NUM_BANKS-1:0];
        default: ;
      endcase
    end
  end

  // array storage kept free of reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_i && region_i == RG_FVAL) fv_mem[sub_i[FV_IW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (wr_i && region_i == RG_MBOX) mb_mem[sub_i[MB_IW-1:0]] <= wdata_i;
  end

  always_comb begin
    case (region_i)
      RG_BTR:  rd_o = btr_o;
      RG_FCFG: rd_o = fcfg_q[sub_i[1:0]];
      RG_FACT: rd_o = 32'(fact_o);
      RG_FVAL: rd_o = fv_mem[sub_i[FV_IW-1:0]];
      RG_MBOX: rd_o = mb_mem[sub_i[MB_IW-1:0]];
      default: rd_o = '0;
    endcase
  end
endmodule

// File: rtl/can_reg_guard.sv
module can_reg_guard
  import can_reg_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int NUM_BANKS   = 14,
  parameter int FBANK_WORDS = 2,
  parameter int NUM_MB      = 3,
  parameter int MB_WORDS    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [3:0]        bus_be,
  input  logic              init_active,
  input  logic              filt_init,
  input  logic [NUM_MB-1:0] mb_empty,
  input  logic              dbg_halt,
  output logic [31:0]       bus_rdata,
  output logic              soft_rst_pulse,
  output logic              freeze,
  output logic              sleep_req,
  output logic              init_req,
  output logic              wr_reject
);
  localparam int WIDX_W   = ADDR_W - 2;
  localparam int FV_WORDS = NUM_BANKS * FBANK_WORDS;
  localparam int MB_TOTAL = NUM_MB * MB_WORDS;
  localparam int IDX_N    = (FV_WORDS > MB_TOTAL) ? FV_WORDS : MB_TOTAL;
  localparam int IDX_W    = (IDX_N > 1) ? $clog2(IDX_N) : 1;

  region_e              region;
  logic [IDX_W-1:0]     sub;
  logic                 allowed;
  logic                 full_word;
  logic                 wr_ok;
  logic                 wr_drop;
  logic [NUM_BANKS-1:0] fact;
  logic [31:0]          btr;
  logic [31:0]          cfg_rd;
  logic [31:0]          mcr;
  logic [31:0]          rd_mux;

  assign full_word = &bus_be;
  assign wr_ok     = bus_we & full_word & allowed & (region != RG_NONE);
  assign wr_drop   = bus_we & (~full_word | ((region != RG_NONE) & ~allowed));

  can_reg_decode #(
    .WIDX_W(WIDX_W), .NUM_BANKS(NUM_BANKS), .FBANK_WORDS(FBANK_WORDS),
    .NUM_MB(NUM_MB), .MB_WORDS(MB_WORDS), .IDX_W(IDX_W)
  ) i_decode (
    .widx_i(bus_addr[ADDR_W-1:2]),
    .aligned_i(bus_addr[1:0] == 2'b00),
    .init_active_i(init_active),
    .filt_init_i(filt_init),
    .mb_empty_i(mb_empty),
    .fact_i(fact),
    .region_o(region),
    .sub_o(sub),
    .allowed_o(allowed)
  );

  can_mcr i_mcr (
    .clk(clk),
    .rst(rst),
    .wr_i(wr_ok && region == RG_MCR),
    .wdata_i(bus_wdata),
    .mcr_o(mcr),
    .soft_rst_o(soft_rst_pulse)
  );

  can_cfg_store #(
    .NUM_BANKS(NUM_BANKS), .FBANK_WORDS(FBANK_WORDS),
    .NUM_MB(NUM_MB), .MB_WORDS(MB_WORDS), .IDX_W(IDX_W)
  ) i_store (
    .clk(clk),
    .rst(rst),
    .wr_i(wr_ok && region != RG_MCR),
    .region_i(region),
    .sub_i(sub),
    .wdata_i(bus_wdata),
    .btr_o(btr),
    .fact_o(fact),
    .rd_o(cfg_rd)
  );

  assign rd_mux    = (region == RG_MCR) ? mcr : cfg_rd;
  assign sleep_req = mcr[MCR_SLEEP_BIT];
  assign init_req  = mcr[MCR_INRQ_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_reject <= 1'b0;
      freeze    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      wr_reject <= wr_drop;
      freeze    <= mcr[MCR_DBF_BIT] & dbg_halt;
      if (bus_re) bus_rdata <= full_word ? rd_mux : 32'h0;
    end
  end

  AST_PARTIAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !full_word) |=> ($stable(mcr) && !soft_rst_pulse)); // R1
  AST_BTR_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(4) && !init_active) |=> $stable(btr)); // R2
  AST_FREEZE_NEEDS_HALT: assert property (@(posedge clk) disable iff (rst)
    freeze |-> $past(dbg_halt)); // R8
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_re && region == RG_MCR) |=> (bus_rdata[31:17] == '0 && bus_rdata[15:8] == '0)); // R9
  AST_REJECT_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_reject |-> $past(bus_we)); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_re && region == RG_NONE) |=> (bus_rdata == '0)); // R11
endmodule

// File: tb/test_can_reg_guard.sv
module test_can_reg_guard;
  localparam int ADDR_W = 10;
  localparam int NUM_MB = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_we = 1'b0;
  logic              bus_re = 1'b0;
  logic [3:0]        bus_be = 4'hF;
  logic              init_active = 1'b0;
  logic              filt_init = 1'b0;
  logic [NUM_MB-1:0] mb_empty = '1;
  logic              dbg_halt = 1'b0;
  logic [31:0]       bus_rdata;
  logic              soft_rst_pulse, freeze, sleep_req, init_req, wr_reject;

  int n_checks = 0;
  int n_fail   = 0;
  logic last_rej, last_pulse;
  logic [31:0] rd;

  always #10 clk = ~clk;

  can_reg_guard #(.ADDR_W(ADDR_W), .NUM_MB(NUM_MB)) i_can_reg_guard (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_be(bus_be),
    .init_active(init_active), .filt_init(filt_init), .mb_empty(mb_empty),
    .dbg_halt(dbg_halt), .bus_rdata(bus_rdata), .soft_rst_pulse(soft_rst_pulse),
    .freeze(freeze), .sleep_req(sleep_req), .init_req(init_req),
    .wr_reject(wr_reject)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
    @(negedge clk);
    last_rej = wr_reject; last_pulse = soft_rst_pulse;
    bus_we = 1'b0; bus_be = 4'hF;
  endtask

  task automatic rdw(input logic [ADDR_W-1:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_re = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_re = 1'b0; bus_be = 4'hF;
  endtask

  task automatic t_reset_state;
    chk("R6 sleep_req", 32'(sleep_req), 32'd1);
    chk("R6 init_req", 32'(init_req), 32'd0);
    chk("R8 freeze", 32'(freeze), 32'd0);
    chk("R10 reject idle", 32'(wr_reject), 32'd0);
    rdw(10'h000, rd);
    chk("R6 control reset value", rd, 32'h0001_0002);
  endtask

  task automatic t_control_bits;
    wr(10'h000, 32'hFFFF_7FFF);
    chk("R10 accepted write", 32'(last_rej), 32'd0);
    rdw(10'h000, rd);
    chk("R9 reserved bits", rd, 32'h0001_00FF);
    chk("R6 init_req set", 32'(init_req), 32'd1);
    wr(10'h000, 32'h0000_0081);
    rdw(10'h000, rd);
    chk("R6 low bits", rd, 32'h0000_0081);
    chk("R6 sleep_req low", 32'(sleep_req), 32'd0);
  endtask

  task automatic t_freeze;
    @(negedge clk); dbg_halt = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 no freeze without bit16", 32'(freeze), 32'd0);
    wr(10'h000, 32'h0001_0000);
    @(negedge clk);
    chk("R8 freeze on", 32'(freeze), 32'd1);
    dbg_halt = 1'b0;
    @(negedge clk);
    chk("R8 freeze off", 32'(freeze), 32'd0);
  endtask

  task automatic t_soft_reset;
    wr(10'h000, 32'h0000_8005);
    chk("R7 pulse", 32'(last_pulse), 32'd1);
    chk("R7 sleep requested", 32'(sleep_req), 32'd1);
    @(negedge clk);
    chk("R7 pulse one cycle", 32'(soft_rst_pulse), 32'd0);
    rdw(10'h000, rd);
    chk("R7 control restored", rd, 32'h0001_0002);
  endtask

  task automatic t_partial;
    wr(10'h000, 32'h0000_0001, 4'b0111);
    chk("R1 partial rejected", 32'(last_rej), 32'd1);
    wr(10'h000, 32'h0000_8000, 4'b0011);
    chk("R1 no reset pulse", 32'(last_pulse), 32'd0);
    rdw(10'h000, rd);
    chk("R1 control unchanged", rd, 32'h0001_0002);
    rdw(10'h000, rd, 4'b1110);
    chk("R1 partial read zero", rd, 32'h0);
  endtask

  task automatic t_btr;
    init_active = 1'b0;
    wr(10'h004, 32'h0000_1234);
    chk("R10 btr drop pulse", 32'(last_rej), 32'd1);
    @(negedge clk);
    chk("R10 pulse one cycle", 32'(wr_reject), 32'd0);
    rdw(10'h004, rd);
    chk("R2 btr locked", rd, 32'h0);
    init_active = 1'b1;
    wr(10'h004, 32'h0000_1234);
    init_active = 1'b0;
    wr(10'h004, 32'h0000_5555);
    rdw(10'h004, rd);
    chk("R2 btr init write kept", rd, 32'h0000_1234);
  endtask

  task automatic t_filter_cfg;
    filt_init = 1'b1;
    wr(10'h008, 32'hA);
    wr(10'h00C, 32'hB);
    wr(10'h010, 32'hC);
    filt_init = 1'b0;
    wr(10'h00C, 32'hF0);
    chk("R4 drop pulse", 32'(last_rej), 32'd1);
    wr(10'h010, 32'hF1);
    rdw(10'h008, rd); chk("R4 mode", rd, 32'hA);
    rdw(10'h00C, rd); chk("R4 scale", rd, 32'hB);
    rdw(10'h010, rd); chk("R4 fifo", rd, 32'hC);
  endtask

  task automatic t_filter_val;
    filt_init = 1'b1;
    wr(10'h104, 32'h1111);
    filt_init = 1'b0;
    wr(10'h014, 32'h1);
    chk("R5 activation writable", 32'(last_rej), 32'd0);
    rdw(10'h014, rd); chk("R5 activation read", rd, 32'h1);
    wr(10'h104, 32'h2222);
    chk("R5 active bank drop", 32'(last_rej), 32'd1);
    wr(10'h108, 32'hCAFE);
    chk("R5 inactive bank accept", 32'(last_rej), 32'd0);
    rdw(10'h104, rd); chk("R5 active bank kept", rd, 32'h1111);
    rdw(10'h108, rd); chk("R5 inactive bank value", rd, 32'hCAFE);
    filt_init = 1'b1;
    wr(10'h104, 32'hBEEF);
    filt_init = 1'b0;
    rdw(10'h104, rd); chk("R5 init overrides", rd, 32'hBEEF);
  endtask

  task automatic t_mailbox;
    mb_empty = 3'b111;
    wr(10'h218, 32'h77);
    wr(10'h204, 32'h66);
    mb_empty = 3'b101;
    wr(10'h218, 32'h99);
    chk("R3 busy mailbox drop", 32'(last_rej), 32'd1);
    wr(10'h204, 32'h88);
    wr(10'h228, 32'h55);
    rdw(10'h218, rd); chk("R3 busy mailbox kept", rd, 32'h77);
    rdw(10'h204, rd); chk("R3 mailbox0 written", rd, 32'h88);
    rdw(10'h228, rd); chk("R3 mailbox2 written", rd, 32'h55);
    mb_empty = 3'b111;
  endtask

  task automatic t_unmapped;
    wr(10'h300, 32'hDEAD);
    chk("R10 unmapped no pulse", 32'(last_rej), 32'd0);
    rdw(10'h000, rd);
    rdw(10'h300, rd); chk("R11 unmapped read", rd, 32'h0);
    rdw(10'h000, rd);
    rdw(10'h018, rd); chk("R11 gap read", rd, 32'h0);
    rdw(10'h000, rd);
    rdw(10'h006, rd); chk("R11 unaligned read", rd, 32'h0);
    @(negedge clk);
    chk("R11 read data holds", bus_rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_control_bits();
    t_freeze();
    t_soft_reset();
    t_partial();
    t_btr();
    t_filter_cfg();
    t_filter_val();
    t_mailbox();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule